// File: doc/BRIEF.md
# Decode-Stage Branch Resolver with Optional Delay Slot

This block is the fetch-side steering logic for a five-stage in-order pipeline whose conditional branches are settled while they sit in the decode stage. A dedicated equality comparator looks at the two register operands of the branch in decode. An adder forms the branch target from the branch's own address and its immediate. A registered program counter then follows the new path from the very next cycle. Because the decision is made this early, only the one instruction fetched behind the branch can be on the wrong path. The block predicts nothing. Once a branch leaves decode, it has no further effect on this logic.

A static mode input chooses what happens to that trailing instruction. In delayed mode it is architecturally part of the program and always runs, so the block never squashes anything. In non-delayed mode a taken branch raises a flush strobe in the following cycle. While the strobe is high, the fetch/decode register holds a squashed instruction: the pipeline zeroes it to the all-zero no-op, and the block ignores any branch decoded from it. A taken branch therefore costs one bubble. A branch that is not taken costs nothing in either mode. A stall from the hazard unit freezes the counter and holds off any redirection until it drops.

Top module: `decode_branch_unit`

## Requirements
- R1: While rstN is low at a clock edge, pcOut loads RESET_PC (default 32'h0000_1000) and flushFd clears to 0, even if a flush was pending.
- R2: brKind 2'b01 is taken exactly when all 32 bits of opA and opB are equal. 2'b10 is taken exactly when they differ in any bit. 2'b00 and 2'b11 are never taken.
- R3: The redirect target is decPc + 4 + (imm sign-extended to 32 bits and shifted left by 2), with wrap-around in 32 bits.
- R4: With stall low, nextPc equals the target when taken is high and pcOut + 4 otherwise, and pcOut takes the value of nextPc at the following clock edge.
- R5: While stall is high, taken is 0, nextPc equals pcOut, and pcOut is unchanged after the edge. A branch held through a stall resolves normally once stall falls.
- R6: With delayMode 0, a taken branch makes flushFd high for exactly the one following cycle.
- R7: With delayMode 1, a taken branch never raises flushFd, so the instruction after it proceeds.
- R8: While flushFd is high, a branch presented on the decode inputs is ignored: taken stays 0 and pcOut advances by 4.
- R9: A branch that is not taken raises no flush and advances pcOut by exactly 4 in either mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| delayMode | input | 1 | 1: the instruction after a branch always runs; 0: it is squashed when the branch is taken |
| stall | input | 1 | Hazard-unit freeze of the PC and of redirection |
| brKind | input | 2 | Branch type in decode: 00 none, 01 equal, 10 not-equal, 11 none |
| opA | input | 32 | First register operand of the branch |
| opB | input | 32 | Second register operand of the branch |
| imm | input | 16 | Signed word offset of the branch |
| decPc | input | 32 | Address of the instruction now in decode |
| pcOut | output | 32 | Registered fetch address |
| nextPc | output | 32 | Fetch address for the next cycle |
| taken | output | 1 | Branch in decode is taken this cycle |
| flushFd | output | 1 | The instruction now in fetch/decode is to be squashed to a no-op |

## Verification
The delicate overlap is a branch that reaches decode in the very cycle its predecessor's flush is active. A redirect and a squash then meet on the same edge. The stimulus table places a matching branch and a non-branch directly behind each taken non-delayed branch. The bench expects taken to stay low, nextPc to be pcOut + 4, and flushFd to drop after one cycle. A second overlap is a reset that arrives while a flush is pending. It is judged by reading flushFd and pcOut right after that edge.

// File: rtl/dbr_pkg.sv
package dbr_pkg;

  typedef enum logic [1:0] {
    BR_NONE = 2'b00,
    BR_EQ   = 2'b01,
    BR_NE   = 2'b10,
    BR_RSVD = 2'b11
  } brKind_e;

  // strobes from control to datapath
  typedef struct packed {
    logic holdPc;
    logic redirect;
  } pcStrobe_t;

endpackage

// File: rtl/dbr_datapath.sv
module dbr_datapath
  import dbr_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int IMM_W = 16,
  parameter int SHIFT = 2,
  parameter int LANES = 4,
  parameter logic [XLEN-1:0] RESET_PC = 32'h0000_1000
) (
  input  logic            clk,
  input  logic            rstN,
  input  pcStrobe_t       strobe,
  input  logic [XLEN-1:0] opA,
  input  logic [XLEN-1:0] opB,
  input  logic [IMM_W-1:0] imm,
  input  logic [XLEN-1:0] decPc,
  output logic            eqFlag,
  output logic [XLEN-1:0] pcOut,
  output logic [XLEN-1:0] nextPc
);

  localparam int LANE_W = XLEN / LANES;
  localparam logic [XLEN-1:0] STEP = XLEN'(1) << SHIFT;

  logic [LANES-1:0] laneEq;
  logic [XLEN-1:0]  pcReg;
  logic [XLEN-1:0]  seqPc;
  logic [XLEN-1:0]  offset;
  logic [XLEN-1:0]  target;

  // operand equality split in lanes, then reduced
  for (genvar g = 0; g < LANES; g++) begin : gLane
    assign laneEq[g] = (opA[g*LANE_W +: LANE_W] == opB[g*LANE_W +: LANE_W]);
  end
  assign eqFlag = &laneEq;

  always_comb begin
    offset = {{(XLEN-IMM_W){imm[IMM_W-1]}}, imm} << SHIFT;
    target = decPc + STEP + offset;
    seqPc  = pcReg + STEP;
    if (strobe.holdPc)        nextPc = pcReg;
    else if (strobe.redirect) nextPc = target;
    else                      nextPc = seqPc;
  end

  always_ff @(posedge clk) begin
    if (!rstN) pcReg <= RESET_PC;
    else       pcReg <= nextPc;
  end

  assign pcOut = pcReg;

endmodule

// File: rtl/dbr_control.sv
module dbr_control
  import dbr_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      delayMode,
  input  logic      stall,
  input  logic [1:0] brKind,
  input  logic      eqFlag,
  output pcStrobe_t strobe,
  output logic      taken,
  output logic      flushFd
);

  brKind_e kind;
  logic    condMet;
  logic    flushQ;

  always_comb begin
    kind    = brKind_e'(brKind);
    condMet = ((kind == BR_EQ) && eqFlag) || ((kind == BR_NE) && !eqFlag);
    // a squashed slot instruction must not steer fetch
    taken           = condMet && !stall && !flushQ;
    strobe.holdPc   = stall;
    strobe.redirect = taken;
  end

  always_ff @(posedge clk) begin
    if (!rstN) flushQ <= 1'b0;
    else       flushQ <= taken && !delayMode;
  end

  assign flushFd = flushQ;

endmodule

// File: rtl/decode_branch_unit.sv
module decode_branch_unit
  import dbr_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int IMM_W = 16,
  parameter int SHIFT = 2,
  parameter int LANES = 4,
  parameter logic [XLEN-1:0] RESET_PC = 32'h0000_1000
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             delayMode,
  input  logic             stall,
  input  logic [1:0]       brKind,
  input  logic [XLEN-1:0]  opA,
  input  logic [XLEN-1:0]  opB,
  input  logic [IMM_W-1:0] imm,
  input  logic [XLEN-1:0]  decPc,
  output logic [XLEN-1:0]  pcOut,
  output logic [XLEN-1:0]  nextPc,
  output logic             taken,
  output logic             flushFd
);

  pcStrobe_t strobe;
  logic      eqFlag;

  dbr_control uCtl (
    .clk(clk), .rstN(rstN), .delayMode(delayMode), .stall(stall),
    .brKind(brKind), .eqFlag(eqFlag), .strobe(strobe),
    .taken(taken), .flushFd(flushFd)
  );

  dbr_datapath #(
    .XLEN(XLEN), .IMM_W(IMM_W), .SHIFT(SHIFT), .LANES(LANES), .RESET_PC(RESET_PC)
  ) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .opA(opA), .opB(opB),
    .imm(imm), .decPc(decPc), .eqFlag(eqFlag), .pcOut(pcOut), .nextPc(nextPc)
  );

endmodule

// File: rtl/decode_branch_unit_chk.sv
module decode_branch_unit_chk #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rstN,
  input logic            delayMode,
  input logic            stall,
  input logic [1:0]      brKind,
  input logic [XLEN-1:0] pcOut,
  input logic            taken,
  input logic            flushFd
);

  // R5
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    stall |=> pcOut == $past(pcOut));

  // R5
  stall_no_take_chk: assert property (@(posedge clk) disable iff (!rstN)
    stall |-> !taken);

  // R6
  flush_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    (taken && !delayMode) |=> flushFd);

  // R6
  flush_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    flushFd |=> !flushFd);

  // R7
  delay_no_flush_chk: assert property (@(posedge clk) disable iff (!rstN)
    (taken && delayMode) |=> !flushFd);

  // R8
  squash_ignore_chk: assert property (@(posedge clk) disable iff (!rstN)
    flushFd |-> !taken);

  // R9
  not_taken_seq_chk: assert property (@(posedge clk) disable iff (!rstN)
    (brKind != 2'b00 && !taken && !stall) |=> (pcOut == $past(pcOut) + 32'd4) && !flushFd);

  // R2
  kind_none_chk: assert property (@(posedge clk) disable iff (!rstN)
    (brKind == 2'b00 || brKind == 2'b11) |-> !taken);

endmodule

bind decode_branch_unit decode_branch_unit_chk #(.XLEN(XLEN)) uChk (
  .clk(clk), .rstN(rstN), .delayMode(delayMode), .stall(stall),
  .brKind(brKind), .pcOut(pcOut), .taken(taken), .flushFd(flushFd)
);

// File: tb/decode_branch_unit_test.sv
module decode_branch_unit_test;

  localparam logic [31:0] RST_PC = 32'h0000_1000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        delayMode = 1'b0;
  logic        stall = 1'b0;
  logic [1:0]  brKind = 2'b00;
  logic [31:0] opA = '0, opB = '0, decPc = '0;
  logic [15:0] imm = '0;
  logic [31:0] pcOut, nextPc;
  logic        taken, flushFd;

  int runCnt = 0;
  int failCnt = 0;
  logic [31:0] modelPc;

  always #10 clk = ~clk;

  decode_branch_unit uut (
    .clk(clk), .rstN(rstN), .delayMode(delayMode), .stall(stall),
    .brKind(brKind), .opA(opA), .opB(opB), .imm(imm), .decPc(decPc),
    .pcOut(pcOut), .nextPc(nextPc), .taken(taken), .flushFd(flushFd)
  );

  typedef struct packed {
    logic        mode;
    logic        stl;
    logic [1:0]  kind;
    logic [31:0] a;
    logic [31:0] b;
    logic [15:0] im;
    logic [31:0] pc;
    logic        expTaken;
    logic [31:0] expTarget;
  } vec_t;

  localparam int NVEC = 12;
  localparam vec_t VECS [NVEC] = '{
    // R2 R3 equal taken, non-delayed
    '{1'b0, 1'b0, 2'b01, 32'd5, 32'd5, 16'h0003, 32'h0000_0100, 1'b1, 32'h0000_0110},
    // R8 matching branch in squashed slot
    '{1'b0, 1'b0, 2'b01, 32'd1, 32'd1, 16'h0001, 32'h0000_0104, 1'b0, 32'h0},
    // R2 R3 not-equal taken, negative offset
    '{1'b0, 1'b0, 2'b10, 32'd1, 32'd2, 16'hFFFF, 32'h0000_0200, 1'b1, 32'h0000_0200},
    // R8 non-branch in squashed slot
    '{1'b0, 1'b0, 2'b00, 32'd0, 32'd0, 16'h0000, 32'h0000_0204, 1'b0, 32'h0},
    // R9 equal not taken
    '{1'b0, 1'b0, 2'b01, 32'd3, 32'd4, 16'h0010, 32'h0000_0208, 1'b0, 32'h0},
    // R9 not-equal not taken
    '{1'b0, 1'b0, 2'b10, 32'd7, 32'd7, 16'h0010, 32'h0000_020C, 1'b0, 32'h0},
    // R7 delayed mode taken
    '{1'b1, 1'b0, 2'b01, 32'd9, 32'd9, 16'h0010, 32'h0000_0300, 1'b1, 32'h0000_0344},
    // R7 R3 delay-slot branch, most negative offset
    '{1'b1, 1'b0, 2'b10, 32'd0, 32'd1, 16'h8000, 32'h0004_0000, 1'b1, 32'h0002_0004},
    // R5 stalled matching branch
    '{1'b0, 1'b1, 2'b01, 32'd6, 32'd6, 16'h0002, 32'h0000_0500, 1'b0, 32'h0},
    // R5 same branch after release
    '{1'b0, 1'b0, 2'b01, 32'd6, 32'd6, 16'h0002, 32'h0000_0500, 1'b1, 32'h0000_050C},
    // R2 reserved kind never taken (flush cycle as well)
    '{1'b0, 1'b0, 2'b11, 32'd8, 32'd8, 16'h0002, 32'h0000_0600, 1'b0, 32'h0},
    // R2 upper bit differs, equal not taken
    '{1'b0, 1'b0, 2'b01, 32'hFFFF_FFFF, 32'h7FFF_FFFF, 16'h0002, 32'h0000_0700, 1'b0, 32'h0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    runCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    failCnt++;
    $display("FAIL watchdog actual=expired expected=done");
    $display("  [TB] %0d tests run, %0d failed", runCnt, failCnt);
    $finish;
  end

  initial begin : main
    logic [31:0] expNext;
    // R1 reset state
    repeat (2) @(posedge clk);
    #1;
    check("R1 pcOut", pcOut, RST_PC);
    check("R1 flushFd", {31'd0, flushFd}, 32'd0);
    @(negedge clk);
    rstN = 1'b1;
    modelPc = RST_PC;

    for (int i = 0; i < NVEC; i++) begin
      delayMode = VECS[i].mode;
      stall     = VECS[i].stl;
      brKind    = VECS[i].kind;
      opA       = VECS[i].a;
      opB       = VECS[i].b;
      imm       = VECS[i].im;
      decPc     = VECS[i].pc;
      #5;
      if (VECS[i].stl)          expNext = modelPc;
      else if (VECS[i].expTaken) expNext = VECS[i].expTarget;
      else                       expNext = modelPc + 32'd4;
      check($sformatf("R2/R5/R8 taken v%0d", i), {31'd0, taken}, {31'd0, VECS[i].expTaken});
      check($sformatf("R3/R4 nextPc v%0d", i), nextPc, expNext);
      @(posedge clk);
      #1;
      modelPc = expNext;
      check($sformatf("R4 pcOut v%0d", i), pcOut, expNext);
      check($sformatf("R6/R7/R9 flushFd v%0d", i), {31'd0, flushFd},
            {31'd0, VECS[i].expTaken & ~VECS[i].mode});
      @(negedge clk);
    end

    // R1 reset while a flush is pending
    delayMode = 1'b0; stall = 1'b0; brKind = 2'b01;
    opA = 32'd4; opB = 32'd4; imm = 16'h0004; decPc = 32'h0000_0800;
    @(posedge clk);
    #1;
    check("R6 flushFd before reset", {31'd0, flushFd}, 32'd1);
    check("R4 pcOut redirect", pcOut, 32'h0000_0814);
    @(negedge clk);
    rstN = 1'b0; brKind = 2'b00;
    @(posedge clk);
    #1;
    check("R1 flush cleared", {31'd0, flushFd}, 32'd0);
    check("R1 pcOut reloaded", pcOut, RST_PC);
    @(negedge clk);
    rstN = 1'b1;

    // R5 multi-cycle stall holds pc
    stall = 1'b1; brKind = 2'b10; opA = 32'd1; opB = 32'd0;
    repeat (3) @(posedge clk);
    #1;
    check("R5 pcOut held", pcOut, RST_PC);
    check("R5 taken low", {31'd0, taken}, 32'd0);
    @(negedge clk);
    stall = 1'b0; brKind = 2'b00;
    @(posedge clk);
    #1;
    check("R9 sequential after stall", pcOut, RST_PC + 32'd4);

    $display("  [TB] %0d tests run, %0d failed", runCnt, failCnt);
    $finish;
  end

endmodule